// File: doc/BRIEF.md
# Microcoded Single-Accumulator Processor Core

This block is a small processor built around one accumulator. It has no pipeline. Its control sequencer moves data between registers through an address register and a data register, one register transfer per clock. Every instruction first runs a fixed four-step fetch:

1. The address register is loaded from the program counter.
2. The word at that address is read into the data register.
3. The opcode is split into the instruction register.
4. The program counter is advanced.

An execute sequence chosen by the opcode then runs. It also moves all of its data through the same two registers.

The program and data share an internal word-addressed memory. A host loads that memory through a simple write port while the core is stopped. The host then pulses a start input. The core runs until it meets a stop instruction, then raises its halted output. The accumulator and the program counter are always visible at the ports. A program's result and its end point can be read there without stopping the core in any special way.

An instruction word holds a 5-bit opcode in bits 15:11 and an 11-bit operand address in bits 10:0. Data words are 16-bit two's complement.

Top module: `uacc_core`

## Requirements
- R1: After reset, `halted_o` is 1 and `acc_o` and `pc_o` are 0. The internal address, data and instruction registers are cleared and the core does not run.
- R2: A one-cycle `start_i` pulse while halted makes `halted_o` low on the next cycle. Execution begins at the current program counter. `start_i` has no effect while running.
- R3: Each instruction begins with a fetch of four clocks: address register from PC, data register from memory, opcode (bits 15:11) into the instruction register, PC plus one. The fetch is then followed by the execute steps for that opcode.
- R4: Opcode 1 (load) takes three execute clocks and sets the accumulator to the memory word at address bits 10:0.
- R5: Opcode 2 (store) takes three execute clocks and writes the accumulator to memory at address bits 10:0.
- R6: Opcodes 5 (add) and 6 (subtract) take three execute clocks. They combine the accumulator with the memory operand, wrapping modulo 2^16.
- R7: Opcode 7 (multiply) takes three execute clocks and keeps only the low 16 bits of accumulator times operand.
- R8: Opcode 15 (jump) takes one execute clock and loads PC with address bits 10:0.
- R9: Opcode 16 (jump if positive) takes one execute clock. It loads PC with the address only when the accumulator is strictly greater than zero as a signed value. A zero or negative accumulator falls through.
- R10: Opcode 21 (stop) takes one execute clock and then raises `halted_o`. PC then points just past the stop word. While halted, PC and the accumulator hold. A later start resumes from that PC.
- R11: Any other opcode takes no execute clocks and changes nothing except the PC advance of the fetch.
- R12: A host write (`host_we_i`) stores `host_data_i` at `host_addr_i` while halted. It is ignored while the core runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that starts execution |
| host_we_i | input | 1 | Host memory write strobe, honoured only while halted |
| host_addr_i | input | 11 | Host write word address |
| host_data_i | input | 16 | Host write data |
| halted_o | output | 1 | High while the core is not executing |
| acc_o | output | 16 | Accumulator value |
| pc_o | output | 11 | Program counter value |

## Verification
A fault in the micro-step sequencing shows first as a wrong number of clocks between the start pulse and the rise of `halted_o`. Each instruction class has its own fixed step count, so the bench compares that span exactly. A fault in the transfer registers or the arithmetic shows in the final accumulator, possibly only after a later load reads back a stored word. A fault in branch handling shows as a wrong final PC or a run of the wrong length. An ignored host write that lands anyway would alter an operand mid-loop and change both the result and the cycle count.

// File: rtl/uacc_pkg.sv
package uacc_pkg;

  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OP_LOAD  = 5'd1;
  localparam logic [OPC_W-1:0] OP_STORE = 5'd2;
  localparam logic [OPC_W-1:0] OP_ADD   = 5'd5;
  localparam logic [OPC_W-1:0] OP_SUB   = 5'd6;
  localparam logic [OPC_W-1:0] OP_MUL   = 5'd7;
  localparam logic [OPC_W-1:0] OP_JMP   = 5'd15;
  localparam logic [OPC_W-1:0] OP_JPOS  = 5'd16;
  localparam logic [OPC_W-1:0] OP_STOP  = 5'd21;

  typedef enum logic [3:0] {
    US_IDLE,
    US_F_AR,
    US_F_RD,
    US_F_IR,
    US_F_INC,
    US_X_AR,
    US_X_RD,
    US_X_LDA,
    US_X_DRA,
    US_X_WR,
    US_X_ALU,
    US_X_JMP,
    US_X_JPOS,
    US_X_STOP
  } ustate_e;

  typedef enum logic [1:0] {
    AOP_PASS,
    AOP_ADD,
    AOP_SUB,
    AOP_MUL
  } aop_e;

  // one micro-operation word, decoded from the sequencer state
  typedef struct packed {
    logic ar_pc;
    logic ar_dr;
    logic dr_mem;
    logic dr_acc;
    logic ir_ld;
    logic pc_inc;
    logic pc_jmp;
    logic pc_jpos;
    logic acc_ld;
    aop_e acc_op;
    logic mem_we;
    logic stop;
  } uctl_t;

endpackage

// File: rtl/uacc_ram.sv
module uacc_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, registered read port: block RAM friendly
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/uacc_seq.sv
module uacc_seq
  import uacc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [OPC_W-1:0] ir_i,
  output uctl_t            ctl_o,
  output logic             halted_o
);

  ustate_e st_q, st_d;
  logic    halted_q;
  ustate_e after_step;

  // gate applied before every fetch: continue only while active
  assign after_step = halted_q ? US_IDLE : US_F_AR;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      US_IDLE:   st_d = start_i ? US_F_AR : US_IDLE;
      US_F_AR:   st_d = US_F_RD;
      US_F_RD:   st_d = US_F_IR;
      US_F_IR:   st_d = US_F_INC;
      US_F_INC: begin
        unique case (ir_i)
          OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_MUL: st_d = US_X_AR;
          OP_JMP:  st_d = US_X_JMP;
          OP_JPOS: st_d = US_X_JPOS;
          OP_STOP: st_d = US_X_STOP;
          default: st_d = after_step;
        endcase
      end
      US_X_AR:   st_d = (ir_i == OP_STORE) ? US_X_DRA : US_X_RD;
      US_X_RD:   st_d = (ir_i == OP_LOAD) ? US_X_LDA : US_X_ALU;
      US_X_DRA:  st_d = US_X_WR;
      US_X_LDA,
      US_X_ALU,
      US_X_WR,
      US_X_JMP,
      US_X_JPOS: st_d = after_step;
      US_X_STOP: st_d = US_IDLE;
      default:   st_d = US_IDLE;
    endcase
  end

  always_comb begin
    ctl_o = '0;
    unique case (st_q)
      US_F_AR:   ctl_o.ar_pc   = 1'b1;
      US_F_RD:   ctl_o.dr_mem  = 1'b1;
      US_F_IR:   ctl_o.ir_ld   = 1'b1;
      US_F_INC:  ctl_o.pc_inc  = 1'b1;
      US_X_AR:   ctl_o.ar_dr   = 1'b1;
      US_X_RD:   ctl_o.dr_mem  = 1'b1;
      US_X_LDA: begin
        ctl_o.acc_ld = 1'b1;
        ctl_o.acc_op = AOP_PASS;
      end
      US_X_DRA:  ctl_o.dr_acc  = 1'b1;
      US_X_WR:   ctl_o.mem_we  = 1'b1;
      US_X_ALU: begin
        ctl_o.acc_ld = 1'b1;
        unique case (ir_i)
          OP_ADD:  ctl_o.acc_op = AOP_ADD;
          OP_SUB:  ctl_o.acc_op = AOP_SUB;
          default: ctl_o.acc_op = AOP_MUL;
        endcase
      end
      US_X_JMP:  ctl_o.pc_jmp  = 1'b1;
      US_X_JPOS: ctl_o.pc_jpos = 1'b1;
      US_X_STOP: ctl_o.stop    = 1'b1;
      default:   ctl_o = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q     <= US_IDLE;
      halted_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (st_q == US_IDLE && start_i) begin
        halted_q <= 1'b0;
      end else if (ctl_o.stop) begin
        halted_q <= 1'b1;
      end
    end
  end

  assign halted_o = halted_q;

endmodule

// File: rtl/uacc_dpath.sv
module uacc_dpath
  import uacc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  uctl_t             ctl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [OPC_W-1:0]  ir_o,
  output logic [DATA_W-1:0] dr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o
);

  logic [ADDR_W-1:0] ar_q, ar_d, pc_q, addr_fld;
  logic [DATA_W-1:0] dr_q, acc_q, alu_res;
  logic [OPC_W-1:0]  ir_q;
  logic              acc_pos;

  assign addr_fld = dr_q[ADDR_W-1:0];
  assign acc_pos  = ~acc_q[DATA_W-1] & (|acc_q);

  // next address drives the RAM read port so data lands one clock later
  always_comb begin
    if (ctl_i.ar_pc)      ar_d = pc_q;
    else if (ctl_i.ar_dr) ar_d = addr_fld;
    else                  ar_d = ar_q;
  end

  always_comb begin
    unique case (ctl_i.acc_op)
      AOP_ADD: alu_res = acc_q + dr_q;
      AOP_SUB: alu_res = acc_q - dr_q;
      AOP_MUL: alu_res = acc_q * dr_q;
      default: alu_res = dr_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ar_q  <= '0;
      dr_q  <= '0;
      ir_q  <= '0;
      pc_q  <= '0;
      acc_q <= '0;
    end else begin
      ar_q <= ar_d;
      if (ctl_i.dr_mem)      dr_q <= rdata_i;
      else if (ctl_i.dr_acc) dr_q <= acc_q;
      if (ctl_i.ir_ld)       ir_q <= dr_q[DATA_W-1 -: OPC_W];
      if (ctl_i.pc_inc)      pc_q <= pc_q + ADDR_W'(1);
      else if (ctl_i.pc_jmp || (ctl_i.pc_jpos && acc_pos)) pc_q <= addr_fld;
      if (ctl_i.acc_ld)      acc_q <= alu_res;
    end
  end

  assign raddr_o = ar_d;
  assign waddr_o = ar_q;
  assign wdata_o = dr_q;
  assign ir_o    = ir_q;
  assign dr_o    = dr_q;
  assign acc_o   = acc_q;
  assign pc_o    = pc_q;

endmodule

// File: rtl/uacc_core.sv
module uacc_core
  import uacc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_data_i,
  output logic              halted_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o
);

  uctl_t             ctl;
  logic [OPC_W-1:0]  ir;
  logic [DATA_W-1:0] dr;
  logic [DATA_W-1:0] rdata, core_wdata, ram_wdata;
  logic [ADDR_W-1:0] raddr, core_waddr, ram_waddr;
  logic              core_we, ram_we;

  if (DATA_W < OPC_W + ADDR_W) begin : g_width_bad
    initial $error("instruction fields do not fit the data word");
  end

  uacc_seq u_seq (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (start_i),
    .ir_i     (ir),
    .ctl_o    (ctl),
    .halted_o (halted_o)
  );

  uacc_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ctl_i   (ctl),
    .rdata_i (rdata),
    .raddr_o (raddr),
    .waddr_o (core_waddr),
    .wdata_o (core_wdata),
    .ir_o    (ir),
    .dr_o    (dr),
    .acc_o   (acc_o),
    .pc_o    (pc_o)
  );

  assign core_we = ctl.mem_we;

  // host owns the write port only while halted
  always_comb begin
    if (halted_o) begin
      ram_we    = host_we_i;
      ram_waddr = host_addr_i;
      ram_wdata = host_data_i;
    end else begin
      ram_we    = core_we;
      ram_waddr = core_waddr;
      ram_wdata = core_wdata;
    end
  end

  uacc_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

endmodule

// File: rtl/uacc_core_chk.sv
module uacc_core_chk
  import uacc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              start_i,
  input logic              halted_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [ADDR_W-1:0] pc_o,
  input uctl_t             ctl_i,
  input logic [OPC_W-1:0]  ir_i,
  input logic [DATA_W-1:0] dr_i,
  input logic              core_we_i
);

  p_idle_frozen_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (halted_o && !start_i) |=> ($stable(pc_o) && $stable(acc_o)));

  p_start_wakes_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (halted_o && start_i) |=> !halted_o);

  p_stop_halts_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    ctl_i.stop |=> halted_o);

  p_ir_matches_word_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ctl_i.pc_inc |-> (ir_i == dr_i[DATA_W-1 -: OPC_W]));

  p_acc_only_on_load_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(acc_o) |-> $past(ctl_i.acc_ld));

  p_core_write_running_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    core_we_i |-> !halted_o);

endmodule

bind uacc_core uacc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .start_i   (start_i),
  .halted_o  (halted_o),
  .acc_o     (acc_o),
  .pc_o      (pc_o),
  .ctl_i     (ctl),
  .ir_i      (ir),
  .dr_i      (dr),
  .core_we_i (core_we)
);

// File: tb/test_uacc_core.sv
module test_uacc_core;

  localparam int DW = 16;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_data = '0;
  logic          halted;
  logic [DW-1:0] acc;
  logic [AW-1:0] pc;

  int n_chk = 0;
  int n_bad = 0;
  int n_done = 0;

  typedef struct {
    logic [DW-1:0] acc;
    logic [AW-1:0] pc;
    int            steps;
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  always #4 clk = ~clk;

  uacc_core #(.DATA_W(DW), .ADDR_W(AW)) i_uacc_core (
    .clk_i       (clk),
    .rst_i       (rst),
    .start_i     (start),
    .host_we_i   (host_we),
    .host_addr_i (host_addr),
    .host_data_i (host_data),
    .halted_o    (halted),
    .acc_o       (acc),
    .pc_o        (pc)
  );

  function automatic logic [DW-1:0] enc(input int op, input int addr);
    return DW'((op << 11) | addr);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic wr(input int addr, input logic [DW-1:0] data);
    @(posedge clk); #2;
    host_we = 1'b1; host_addr = AW'(addr); host_data = data;
    @(posedge clk); #2;
    host_we = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #2 rst = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
  endtask

  // driver: queue the expected outcome, then pulse start
  task automatic run(input logic [DW-1:0] e_acc, input int e_pc, input int e_steps,
                     input string tag, input bit poke, input int p_addr,
                     input logic [DW-1:0] p_data);
    exp_t e;
    int target;
    e.acc = e_acc; e.pc = AW'(e_pc); e.steps = e_steps; e.tag = tag;
    exp_q.push_back(e);
    target = n_done + 1;
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    if (poke) begin
      repeat (8) @(posedge clk);
      #2;
      host_we = 1'b1; host_addr = AW'(p_addr); host_data = p_data;
      @(posedge clk); #2 host_we = 1'b0;
    end
    while (n_done < target) @(negedge clk);
  endtask

  // monitor: count micro-steps from start to the rise of halted
  initial begin
    bit prev_h = 1'b1;
    bit running = 1'b0;
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        running = 1'b0;
        prev_h  = 1'b1;
      end else begin
        if (running) begin
          if (halted && !prev_h) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, "acc", int'(acc), int'(e.acc));
            chk(e.tag, "pc", int'(pc), int'(e.pc));
            chk(e.tag, "steps", cnt, e.steps);
            running = 1'b0;
            n_done++;
          end else begin
            cnt++;
          end
        end
        if (start && halted) begin
          running = 1'b1;
          cnt = 0;
        end
        prev_h = halted;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=running expected=halted");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk("R1", "halted", int'(halted), 1);
    chk("R1", "acc", int'(acc), 0);
    chk("R1", "pc", int'(pc), 0);

    // arithmetic chain with store: 7+5-3 = 9, 9*-2 = 0xFFEE
    wr(100, 16'd7); wr(101, 16'd5); wr(102, 16'd3); wr(103, 16'hFFFE);
    wr(0, enc(1, 100)); wr(1, enc(5, 101)); wr(2, enc(6, 102));
    wr(3, enc(7, 103)); wr(4, enc(2, 104)); wr(5, enc(21, 0));
    run(16'hFFEE, 6, 40, "R3 R4 R6 R7 R5 R10", 1'b0, 0, '0);

    // read back the stored word after reset
    do_reset();
    wr(0, enc(1, 104)); wr(1, enc(21, 0));
    run(16'hFFEE, 2, 12, "R5 store readback", 1'b0, 0, '0);

    // countdown loop, positive branch taken, zero falls through; host poke ignored
    do_reset();
    wr(50, 16'd3); wr(51, 16'd1);
    wr(0, enc(1, 50)); wr(1, enc(6, 51)); wr(2, enc(16, 1)); wr(3, enc(21, 0));
    run(16'h0000, 4, 48, "R9 R12 R6 loop", 1'b1, 51, 16'd2);

    // jump, negative falls through, undefined opcode, multiply and add wrap
    do_reset();
    wr(60, 16'h8000); wr(61, 16'd3); wr(62, 16'h7FFF); wr(63, 16'd2);
    wr(0, enc(15, 5)); wr(1, enc(21, 0));
    wr(5, enc(1, 60)); wr(6, enc(16, 1)); wr(7, enc(3, 0));
    wr(8, enc(7, 61)); wr(9, enc(6, 62)); wr(10, enc(5, 63));
    wr(11, enc(21, 0));
    // 0x8000*3 -> 0x8000; -0x7FFF -> 0x0001; +2 -> 0x0003
    run(16'h0003, 12, 47, "R8 R9 R11 R7 R6 wrap", 1'b0, 0, '0);

    // restart without reset resumes at the word after the stop
    wr(12, enc(1, 104)); wr(13, enc(21, 0));
    run(16'hFFEE, 14, 12, "R10 R2 resume", 1'b0, 0, '0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule